// File: doc/BRIEF.md
# Undecimated Two-Level Wavelet Detail Extractor

This block is a streaming filter bank for a DC line protection front end. Four signed sample streams enter in lock-step under one valid strobe: positive-pole current, negative-pole current, positive-pole voltage and negative-pole voltage. For every accepted sample the block produces, per channel, one level-1 and one level-2 detail coefficient of a stationary (undecimated) wavelet transform. It uses an 8-tap Daubechies wavelet. Nothing is decimated, so both detail streams keep the full input sample rate and time alignment.

Level 1 filters the input with the high-pass and low-pass analysis filters. The low-pass result is the level-1 approximation. Level 2 applies the same high-pass filter to that approximation with one zero inserted between neighbouring taps. The filter therefore reaches back across 15 approximation samples but multiplies only every second one. Filter taps are fixed Q1.15 constants. Products are summed at full precision and rounded once per level. All channels and both levels come out together under a single output strobe, a fixed two cycles after the input strobe.

Top module: `swt_detail4`

## Requirements
- R1: While reset is applied, and on the first cycle after it, `out_valid` is low and every `det1`/`det2` lane reads zero.
- R2: Each input strobe yields exactly one `out_valid` pulse, two clock cycles after the cycle in which `in_valid` was high. `out_valid` is never high otherwise. One strobe covers all four channels and both levels.
- R3: The level-1 detail for sample n is round(sum over k=0..7 of hi[k]*x[n-k] / 2^15). Rounding adds 2^14 and then shifts arithmetically right by 15. The low-pass taps lo[0..7] are -347, 1078, 1011, -6129, -917, 20673, 23424, 7549. The high-pass taps are hi[k] = -lo[7-k] for even k and +lo[7-k] for odd k.
- R4: The level-1 approximation a1[n] = round(sum over k of lo[k]*x[n-k] / 2^15), with the R3 rounding, is kept as an 18-bit signed value and is never observed directly.
- R5: The level-2 detail is round(sum over k=0..7 of hi[k]*a1[n-2k] / 2^15). This is the level-1 high-pass filter with zeros inserted between its taps, spanning 15 approximation samples.
- R6: After reset, every sample not yet received counts as zero in both levels, and outputs are produced from the first strobe on.
- R7: Only strobed samples advance the filters. Idle cycles between strobes leave the results identical to a gap-free stream of the same samples.
- R8: Between strobes, the `det1`/`det2` lanes hold their last values.
- R9: Lane index c of `in_sample`, `det1` and `det2` belongs to one channel (0 positive-pole current, 1 negative-pole current, 2 positive-pole voltage, 3 negative-pole voltage). Lanes are filtered independently with no cross-talk.
- R10: Any sequence of 16-bit full-scale inputs fits the 18-bit detail outputs and 18-bit approximation without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for all lanes |
| in_sample | input | NCH*IN_W | Packed signed input samples, lane c at [c] |
| out_valid | output | 1 | Detail strobe, two cycles after `in_valid` |
| det1 | output | NCH*OUT_W | Packed signed level-1 detail per lane |
| det2 | output | NCH*OUT_W | Packed signed level-2 detail per lane |

## Verification
The bench builds the block with its defaults: four lanes, 16-bit input, 18-bit approximation and outputs, and 8 taps. With those values, a 16-sample impulse run shows the whole 15-position level-2 reach filling from zero. Patterns of full-scale 16-bit inputs whose signs line up with the high-pass taps drive the level-1 detail close to its largest magnitude within the 18-bit range. A bit-exact integer model with its own tap table predicts every lane on every strobe, under back-to-back strobes, irregular gaps and a reset in mid-stream.

// File: rtl/swt_pkg.sv
package swt_pkg;

    localparam int NTAPS  = 8;
    localparam int COEF_W = 16;
    localparam int FRAC   = 15;

    typedef enum logic {FLT_LOW, FLT_HIGH} filt_e;

    // Low-pass analysis taps, Q1.15
    function automatic logic signed [COEF_W-1:0] lo_coef(input int k);
        case (k)
            0: return -16'sd347;
            1: return  16'sd1078;
            2: return  16'sd1011;
            3: return -16'sd6129;
            4: return -16'sd917;
            5: return  16'sd20673;
            6: return  16'sd23424;
            7: return  16'sd7549;
            default: return '0;
        endcase
    endfunction

    // Quadrature mirror of the low-pass set
    function automatic logic signed [COEF_W-1:0] hi_coef(input int k);
        logic signed [COEF_W-1:0] c;
        c = lo_coef(NTAPS - 1 - k);
        return (k % 2 == 0) ? -c : c;
    endfunction

    // Round to nearest, ties toward +inf, drop FRAC bits
    function automatic logic signed [63:0] round_q(input logic signed [63:0] v);
        return (v + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    endfunction

    function automatic logic fits(input logic signed [63:0] v, input int w);
        return (v >= -(64'sd1 <<< (w - 1))) && (v < (64'sd1 <<< (w - 1)));
    endfunction

endpackage

// File: rtl/swt_tapline.sv
module swt_tapline #(
    parameter int W      = 16,
    parameter int TAPS   = 8,
    parameter int STRIDE = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [W-1:0]         din,
    output logic [TAPS-1:0][W-1:0] taps
);
    localparam int DEPTH = (TAPS - 1) * STRIDE;

    logic [DEPTH-1:0][W-1:0] hist;   // hist[0] is the newest stored sample

    always_ff @(posedge clk) begin
        if (rst)
            hist <= '0;
        else if (en)
            hist <= {hist[DEPTH-2:0], din};
    end

    assign taps[0] = din;
    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        assign taps[k] = hist[k*STRIDE-1];
    end

    // R7: history moves only on a strobe
    a_r7_frozen_when_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(hist));

endmodule

// File: rtl/swt_fir.sv
module swt_fir #(
    parameter int             W    = 16,
    parameter int             TAPS = 8,
    parameter swt_pkg::filt_e KIND = swt_pkg::FLT_HIGH,
    parameter int             ACCW = W + swt_pkg::COEF_W + 3
) (
    input  logic [TAPS-1:0][W-1:0] taps,
    output logic signed [ACCW-1:0] acc
);
    logic signed [ACCW-1:0] prod [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        localparam logic signed [swt_pkg::COEF_W-1:0] C =
            (KIND == swt_pkg::FLT_HIGH) ? swt_pkg::hi_coef(k) : swt_pkg::lo_coef(k);
        logic signed [ACCW-1:0] xe;
        logic signed [ACCW-1:0] ce;
        assign xe = ACCW'($signed(taps[k]));
        assign ce = ACCW'(C);
        assign prod[k] = xe * ce;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++)
            acc = acc + prod[k];
    end

endmodule

// File: rtl/swt_chan.sv
module swt_chan #(
    parameter int IW   = 16,
    parameter int AW   = 18,
    parameter int OW   = 18,
    parameter int TAPS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          st1_valid,
    input  logic [IW-1:0] x,
    output logic [OW-1:0] d1,
    output logic [OW-1:0] d2
);
    import swt_pkg::*;

    localparam int ACC1 = IW + COEF_W + 3;
    localparam int ACC2 = AW + COEF_W + 3;

    logic [TAPS-1:0][IW-1:0] taps1;
    logic [TAPS-1:0][AW-1:0] taps2;
    logic signed [ACC1-1:0]  lo1_acc, hi1_acc;
    logic signed [ACC2-1:0]  hi2_acc;
    logic signed [63:0]      a1_r, d1_r, d2_r;
    logic [AW-1:0]           a1_q;
    logic [OW-1:0]           d1_q;

    // Level 1: contiguous taps
    swt_tapline #(.W(IW), .TAPS(TAPS), .STRIDE(1)) u_line1 (
        .clk(clk), .rst(rst), .en(in_valid), .din(x), .taps(taps1));

    swt_fir #(.W(IW), .TAPS(TAPS), .KIND(FLT_LOW), .ACCW(ACC1)) u_lo1 (
        .taps(taps1), .acc(lo1_acc));

    swt_fir #(.W(IW), .TAPS(TAPS), .KIND(FLT_HIGH), .ACCW(ACC1)) u_hi1 (
        .taps(taps1), .acc(hi1_acc));

    assign a1_r = round_q(64'(lo1_acc));
    assign d1_r = round_q(64'(hi1_acc));

    always_ff @(posedge clk) begin
        if (rst) begin
            a1_q <= '0;
            d1_q <= '0;
        end else if (in_valid) begin
            a1_q <= AW'(a1_r);
            d1_q <= OW'(d1_r);
        end
    end

    // Level 2: taps every second approximation sample (zero-stuffed filter)
    swt_tapline #(.W(AW), .TAPS(TAPS), .STRIDE(2)) u_line2 (
        .clk(clk), .rst(rst), .en(st1_valid), .din(a1_q), .taps(taps2));

    swt_fir #(.W(AW), .TAPS(TAPS), .KIND(FLT_HIGH), .ACCW(ACC2)) u_hi2 (
        .taps(taps2), .acc(hi2_acc));

    assign d2_r = round_q(64'(hi2_acc));

    always_ff @(posedge clk) begin
        if (rst) begin
            d1 <= '0;
            d2 <= '0;
        end else if (st1_valid) begin
            d1 <= d1_q;
            d2 <= OW'(d2_r);
        end
    end

    // R4: approximation fits its register
    a_r4_approx_fits: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> fits(a1_r, AW));

    // R10: neither detail level overflows the output width
    a_r10_no_overflow_l1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> fits(d1_r, OW));
    a_r10_no_overflow_l2: assert property (@(posedge clk) disable iff (rst)
        st1_valid |-> fits(d2_r, OW));

    // R8: outputs hold between strobes
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !st1_valid |=> ($stable(d1) && $stable(d2)));

endmodule

// File: rtl/swt_detail4.sv
module swt_detail4 #(
    parameter int NCH   = 4,
    parameter int IN_W  = 16,
    parameter int APP_W = 18,
    parameter int OUT_W = 18,
    parameter int TAPS  = swt_pkg::NTAPS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [NCH-1:0][IN_W-1:0]    in_sample,
    output logic                        out_valid,
    output logic [NCH-1:0][OUT_W-1:0]   det1,
    output logic [NCH-1:0][OUT_W-1:0]   det2
);
    logic st1_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1_valid <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            st1_valid <= in_valid;
            out_valid <= st1_valid;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        swt_chan #(.IW(IN_W), .AW(APP_W), .OW(OUT_W), .TAPS(TAPS)) u_chan (
            .clk(clk), .rst(rst), .in_valid(in_valid), .st1_valid(st1_valid),
            .x(in_sample[c]), .d1(det1[c]), .d2(det2[c]));
    end

    // R2: fixed two-cycle strobe latency, no spurious strobes
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/swt_detail4_test.sv
module swt_detail4_test;

    localparam int NCH = 4;
    localparam int IW  = 16;
    localparam int OW  = 18;
    localparam int NT  = 24;

    localparam int LO[8] = '{-347, 1078, 1011, -6129, -917, 20673, 23424, 7549};
    localparam int HI[8] = '{-7549, 23424, -20673, -917, 6129, 1011, -1078, -347};

    localparam int TBL[NT][NCH] = '{
        '{ 1200,  -300,  5000,  -5000}, '{ 2400,  -700,  5100,  -4900},
        '{ 3900, -1500,  5300,  -4700}, '{ 6100, -2600,  4800,  -5200},
        '{ 9000, -4100,  4000,  -6000}, '{12000, -6300, -2000,   2000},
        '{15000, -9000,-12000,  12000}, '{14000,-11000,-20000,  20000},
        '{ 8000,-12000,-25000,  25000}, '{ -500,-10000,-27000,  26000},
        '{-7000, -6000,-20000,  21000}, '{-9999,  -100,-10000,   9000},
        '{  123,   456,   789,  -1011}, '{32767,-32768, 32767, -32768},
        '{-32768, 32767,-32768,  32767}, '{  0,       0,     0,      0},
        '{ 4321, -1234, 17000, -17000}, '{-4321,  1234,-17000,  17000},
        '{  777,  -777,   333,   -333}, '{20000, 20000,-20000, -20000},
        '{-1500,  2500, -3500,   4500}, '{  300,  -300,   300,   -300},
        '{11111,-22222, 30000, -30000}, '{   -1,     1,    -1,      1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [NCH-1:0][IW-1:0] in_sample = '0;
    logic out_valid;
    logic [NCH-1:0][OW-1:0] det1;
    logic [NCH-1:0][OW-1:0] det2;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    always #2 clk = ~clk;   // 250 MHz

    swt_detail4 uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .det1(det1), .det2(det2));

    // Reference model state
    longint xh [NCH][8];
    longint ah [NCH][15];
    longint q1 [$];
    longint q2 [$];
    longint last1 [NCH];
    longint last2 [NCH];
    logic iv_d1 = 1'b0;
    logic iv_d2 = 1'b0;

    function automatic longint rnd(longint s);
        return (s + 64'sd16384) >>> 15;
    endfunction

    task automatic chk(string t, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                for (int k = 0; k < 8; k++) xh[c][k] = 0;
                for (int k = 0; k < 15; k++) ah[c][k] = 0;
                last1[c] = 0;
                last2[c] = 0;
            end
            q1.delete();
            q2.delete();
            iv_d1 = 1'b0;
            iv_d2 = 1'b0;
        end else begin
            chk("R2", "out_valid timing", longint'(out_valid), longint'(iv_d2));
            if (out_valid && q1.size() >= NCH) begin
                for (int c = 0; c < NCH; c++) begin
                    longint e1, e2;
                    e1 = q1.pop_front();
                    e2 = q2.pop_front();
                    chk({tag, " R3 R9"}, $sformatf("det1 lane %0d", c),
                        longint'($signed(det1[c])), e1);
                    chk({tag, " R4 R5 R9"}, $sformatf("det2 lane %0d", c),
                        longint'($signed(det2[c])), e2);
                    last1[c] = e1;
                    last2[c] = e2;
                end
            end else if (!out_valid) begin
                for (int c = 0; c < NCH; c++) begin
                    chk("R8", $sformatf("det1 hold lane %0d", c),
                        longint'($signed(det1[c])), last1[c]);
                    chk("R8", $sformatf("det2 hold lane %0d", c),
                        longint'($signed(det2[c])), last2[c]);
                end
            end
            iv_d2 = iv_d1;
            iv_d1 = in_valid;
            if (in_valid) begin
                for (int c = 0; c < NCH; c++) begin
                    longint sa, sd, s2;
                    for (int k = 7; k > 0; k--) xh[c][k] = xh[c][k-1];
                    xh[c][0] = longint'($signed(in_sample[c]));
                    sa = 0;
                    sd = 0;
                    for (int k = 0; k < 8; k++) begin
                        sa += LO[k] * xh[c][k];
                        sd += HI[k] * xh[c][k];
                    end
                    for (int k = 14; k > 0; k--) ah[c][k] = ah[c][k-1];
                    ah[c][0] = rnd(sa);
                    s2 = 0;
                    for (int k = 0; k < 8; k++) s2 += HI[k] * ah[c][2*k];
                    q1.push_back(rnd(sd));
                    q2.push_back(rnd(s2));
                end
            end
        end
    end

    task automatic send(input int v0, input int v1, input int v2, input int v3);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_sample[0] = 16'(v0);
        in_sample[1] = 16'(v1);
        in_sample[2] = 16'(v2);
        in_sample[3] = 16'(v3);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_sample = '0;
        end
    endtask

    task automatic check_zero(string t);
        @(negedge clk);
        chk(t, "out_valid after reset", longint'(out_valid), 0);
        for (int c = 0; c < NCH; c++) begin
            chk(t, $sformatf("det1 lane %0d after reset", c), longint'($signed(det1[c])), 0);
            chk(t, $sformatf("det2 lane %0d after reset", c), longint'($signed(det2[c])), 0);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_zero("R1");

        // R6: impulse into empty lines, full level-2 fill
        tag = "R6";
        send(1000, 0, 0, -1000);
        for (int i = 0; i < 16; i++) send(0, 0, 0, 0);
        idle(3);

        // Table walk, back-to-back strobes
        tag = "R3 table";
        for (int i = 0; i < NT; i++) send(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3]);
        idle(3);

        // R7 and R8: irregular gaps between strobes
        tag = "R7";
        for (int i = 0; i < 20; i++) begin
            send((i * 1237) % 30000 - 15000, 2000 - i * 300, (i * 977) % 9000, -i * 411);
            idle(1 + (i % 3));
        end

        // R10: full-scale signs aligned with the high-pass taps
        tag = "R10";
        for (int i = 0; i < 32; i++) begin
            int sgn;
            sgn = HI[7 - (i % 8)] > 0 ? 32767 : -32768;
            send(sgn, -sgn - 1, sgn, (i % 2 == 0) ? 32767 : -32768);
        end
        idle(3);

        // R9: distinct signal per lane
        tag = "R9";
        for (int i = 0; i < 20; i++) send(i * 800, 0, 12345, -i * 700);
        idle(3);

        // R1 again: reset mid-stream, then R6 impulse on one lane
        send(5000, 5000, 5000, 5000);
        send(6000, 6000, 6000, 6000);
        @(posedge clk);
        #1 rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        check_zero("R1");
        tag = "R6";
        send(0, 0, 0, 30000);
        for (int i = 0; i < 16; i++) send(0, 0, 0, 0);
        idle(4);

        summary();
        $finish;
    end

endmodule